// File: doc/BRIEF.md
# Centisecond Elapsed-Time Counter

This block measures elapsed time from a fast system clock. It gives the result as two binary values: whole seconds and hundredths of a second. A prescaler divides the system clock down to one advance every hundredth of a second. A chain of two modulo-100 counters then turns those advances into a hundredths field and a seconds field. With the default divisor of 1,000,000 and a 100 MHz clock, each advance marks 10 ms. A smaller divisor can be set so that a simulation reaches the full range in a few thousand cycles.

A controlling state machine uses two inputs. `run` lets time advance. `clear` zeroes the whole time value, and the prescaler's partial count goes with it. While `run` is low, nothing moves, and that includes the prescaler phase. Resuming therefore continues exactly where the count stopped. After 99.99 s the value returns to 00.00 and counting goes on.

Top module: `centisecond_timer`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, both outputs and the prescaler phase become zero. This applies whatever `run` and `clear` are doing.
- R2: Let N be the number of rising edges since the last zeroing at which `run`=1, `clear`=0 and `rst_n`=1. Then `count_cs` equals floor(N/DIV) mod 100.
- R3: `count_cs` never exceeds 99. The advance that would take it past 99 returns it to 0.
- R4: `count_sec` equals floor(N/(100*DIV)) mod 100. It advances on the same edge at which `count_cs` goes from 99 to 0, and on no other edge.
- R5: An edge with `run`=0 and `clear`=0 leaves both outputs and the prescaler phase unchanged. When counting resumes, it continues from the partial phase that was held.
- R6: An edge with `clear`=1 makes both outputs zero and restarts the prescaler phase.
- R7: When `clear` and `run` are both 1 at the same edge, clearing wins and no advance happens.
- R8: The advance after 99.99 gives 00.00, and counting continues from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | High to let time advance |
| clear | input | 1 | High to zero the time value and the prescaler phase |
| count_sec | output | 7 | Whole seconds, binary 0 to 99 |
| count_cs | output | 7 | Hundredths of a second, binary 0 to 99 |

## Verification
The bench runs the timer with a divisor of 3 and keeps an arithmetic model of the count. It compares both outputs against the model on every cycle, all the way through the 99.99 wrap and past it.

The corner cases are chosen to expose specific faults:
- A pause in mid-phase: a prescaler that keeps running while paused, or that restarts on resume, gives a hundredths step that comes early or late.
- A clear or reset in mid-phase: a clear that leaves the phase alone gives the first advance too soon.
- `clear` together with `run`: a design that gives `run` priority shows 00.01 instead of 00.00.
- The 99 → 0 boundaries: an off-by-one limit shows 100. A late carry shows the seconds field one cycle behind. A missing final wrap shows 100.00.

// File: rtl/centisecond_timer_pkg.sv
// Shared constants for the centisecond timer.
// Assumes: decimal fields counting 0..99 and a 100 MHz system clock by default.
package centisecond_timer_pkg;
    localparam int unsigned FIELD_MAX   = 99;
    localparam int unsigned CLK_PER_CS  = 1_000_000;
    localparam int unsigned FIELD_COUNT = 2;
endpackage

// File: rtl/cs_prescaler.sv
// Divides the clock into a one-cycle advance pulse every DIV counting cycles.
// Assumes: the phase moves only while run is high, and clear restarts it at zero.
module cs_prescaler #(
    parameter int unsigned DIV = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic tick
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase;

    // Phase register: zero on reset or clear, step only while running.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            phase <= '0;
        else if (run)
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end

    // Advance pulse on the last phase of a running cycle.
    always_comb tick = run && !clear && (phase == LAST);

    // R5
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear) |=> $stable(phase));
    // R6
    phase_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (phase == '0));
    // R1
    phase_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (phase == '0));
endmodule

// File: rtl/wrap_counter.sv
// Modulo (MAX+1) counter that steps on adv and flags its own wrap.
// Assumes: clr takes priority over adv; wrap is combinational from adv.
module wrap_counter #(
    parameter int unsigned MAX = 99,
    localparam int unsigned W = $clog2(MAX + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    output logic [W-1:0] value,
    output logic         wrap
);
    localparam logic [W-1:0] TOP = W'(MAX);

    // Field register: zero on reset or clear, step or wrap on advance.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            value <= '0;
        else if (adv)
            value <= (value == TOP) ? '0 : value + 1'b1;
    end

    // Carry out to the next field when advancing from the top value.
    always_comb wrap = adv && !clr && (value == TOP);

    // R3
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        value <= TOP);
    // R3
    top_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && value == TOP) |=> (value == '0));
endmodule

// File: rtl/centisecond_timer.sv
// Elapsed-time counter: prescaler followed by a chain of modulo-100 fields.
// Assumes: field 0 is hundredths and field 1 is seconds; clear outranks run.
module centisecond_timer #(
    parameter int unsigned DIV = centisecond_timer_pkg::CLK_PER_CS
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       clear,
    output logic [6:0] count_sec,
    output logic [6:0] count_cs
);
    import centisecond_timer_pkg::*;

    localparam int unsigned NF = FIELD_COUNT;
    localparam int unsigned FW = $clog2(FIELD_MAX + 1);

    logic          tick;
    logic [NF-1:0] adv;
    logic [NF-1:0] wrap;
    logic [FW-1:0] field [NF];

    cs_prescaler #(.DIV(DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .clear(clear), .tick(tick)
    );

    // Cascade: each field advances on the wrap of the one below it.
    for (genvar i = 0; i < NF; i++) begin : g_field
        if (i == 0) begin : g_first
            assign adv[i] = tick;
        end else begin : g_next
            assign adv[i] = wrap[i-1];
        end
        wrap_counter #(.MAX(FIELD_MAX)) u_fld (
            .clk(clk), .rst_n(rst_n), .clr(clear), .adv(adv[i]),
            .value(field[i]), .wrap(wrap[i])
        );
    end

    // Field outputs.
    always_comb begin
        count_cs  = field[0];
        count_sec = field[1];
    end

    // R4
    carry_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(clear) && (count_sec != $past(count_sec)))
        |-> ($past(count_cs) == 7'd99 && count_cs == 7'd0));
    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear) |=> ($stable(count_cs) && $stable(count_sec)));
    // R7
    clear_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && run) |=> (count_cs == 7'd0 && count_sec == 7'd0));
    // R8
    full_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap[NF-1] |=> (count_cs == 7'd0 && count_sec == 7'd0));
    // R1
    reset_chk: assert property (@(posedge clk)
        !rst_n |=> (count_cs == 7'd0 && count_sec == 7'd0));
endmodule

// File: tb/centisecond_timer_test.sv
module centisecond_timer_test;
    localparam int DIV = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic clear = 1'b0;
    logic [6:0] count_sec, count_cs;

    int checks = 0;
    int failures = 0;
    int n = 0;
    bit done = 0;

    always #4 clk = ~clk;

    centisecond_timer #(.DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .run(run), .clear(clear),
        .count_sec(count_sec), .count_cs(count_cs)
    );

    task automatic check(input string tag);
        int ecs, esec;
        ecs  = (n / DIV) % 100;
        esec = (n / (100 * DIV)) % 100;
        checks++;
        if (count_cs !== 7'(ecs) || count_sec !== 7'(esec)) begin
            failures++;
            $display("FAIL %s n=%0d actual=%0d.%0d expected=%0d.%0d",
                     tag, n, count_sec, count_cs, esec, ecs);
        end
    endtask

    // One clock: drive inputs, update the model at the edge, check after it.
    task automatic cyc(input logic r, input logic c, input string tag);
        run = r;
        clear = c;
        @(posedge clk);
        #1;
        if (!rst_n || c) n = 0;
        else if (r) n++;
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        // R1: reset dominates run
        for (int i = 0; i < 3; i++) cyc(1, 0, "R1");
        rst_n = 1'b1;
        cyc(1, 0, "R2");
        cyc(1, 0, "R2");
        rst_n = 1'b0;
        cyc(1, 0, "R1");
        rst_n = 1'b1;
        for (int i = 0; i < 2 * DIV; i++) cyc(1, 0, "R1");
        // R5: pause mid-phase, then resume
        cyc(1, 0, "R5");
        for (int i = 0; i < 20; i++) cyc(0, 0, "R5");
        for (int i = 0; i < 4 * DIV; i++) cyc(1, 0, "R5");
        // R2 R3 R4: count through 1.05 s
        while (n < 105 * DIV) cyc(1, 0, "R4");
        // R7: clear with run in mid-phase
        cyc(1, 0, "R2");
        cyc(1, 1, "R7");
        for (int i = 0; i < 2 * DIV + 1; i++) cyc(1, 0, "R7");
        // R6: clear while paused
        cyc(0, 1, "R6");
        cyc(0, 0, "R6");
        for (int i = 0; i < DIV; i++) cyc(1, 0, "R6");
        // R3 R4 R8: run past 99.99 and keep going
        while (n < 9999 * DIV) cyc(1, 0, "R3");
        for (int i = 0; i < 3 * DIV; i++) cyc(1, 0, "R8");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule